// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital controller of an integrating analog-to-digital converter of the dual-slope kind. A single cycle counter walks through three phases in a fixed order: zeroing, signal integration, then reference run-down, and back to zeroing. From the phase it decodes the drive levels for nine analog switches. At the close of integration it captures the comparator's sign. During run-down it counts clocks until the comparator reports that the integrator has crossed back through its zero point.

A zero crossing does not shorten the cycle. The count freezes, the switches fall back to the zeroing set, and the counter runs on to the end of the run-down window, so every conversion takes the same number of clocks. When the window ends, the block presents a magnitude, a sign and an over-range flag, and it marks the new result with a one-clock strobe. A run input chooses between back-to-back conversions and parking in the zeroing phase between them.

Top module: `dsadc_seq`

## Requirements
- R1: A conversion cycle lasts exactly AZ_LEN + INT_LEN + 2*INT_LEN clocks, which is 131072 with the defaults. The phases follow the order zeroing (`phase`=0), integrate (`phase`=1), run-down (`phase`=2). The length does not depend on the comparator input.
- R2: In the zeroing phase, `sw` equals 9'h10B. Switch n drives bit n-1, so switches 1, 2, 4 and 9 are on.
- R3: In the integrate phase, `sw` equals 9'h10C (switches 3, 4 and 9 on). Switches 1 and 3 are never on together.
- R4: The sign is taken from `cmp` (1 = positive) on the last integrate clock only. Values of `cmp` earlier in integration have no effect.
- R5: In run-down before any crossing, a positive sign gives `sw` = 9'h0C0 (switches 7 and 8) and a negative sign gives `sw` = 9'h120 (switches 6 and 9). No other switches are on.
- R6: A zero crossing is run-down clock k (counting from 0) on which `cmp` differs from the captured sign. The reported count is then k, and from clock k+1 to the end of the window `sw` returns to 9'h10B.
- R7: If the run-down window closes without a crossing, `res_ovr` is 1 and `res_cnt` is 2*INT_LEN. Otherwise `res_ovr` is 0.
- R8: `res_valid` is high for exactly one clock, on the clock that follows the last run-down clock. `res_cnt`, `res_neg` (1 = negative sign) and `res_ovr` change only on that edge.
- R9: The run input is sampled only at the first zeroing clock. While it is high, cycles repeat with no gap. While it is low, the block holds zeroing with the last result kept, and a cycle starts on the clock after the input returns high. A low level in mid-cycle has no effect.
- R10: During reset, `phase` is 0, `sw` is 9'h10B, `res_valid` is 0, and `res_cnt`, `res_neg` and `res_ovr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_hold | input | 1 | 1 = free-running conversions, 0 = park in zeroing at cycle start |
| cmp | input | 1 | Comparator output, 1 = integrator on the positive side |
| sw | output | 9 | Analog switch drives, bit n-1 controls switch n |
| phase | output | 2 | 0 zeroing, 1 integrate, 2 run-down |
| res_valid | output | 1 | One-clock strobe marking a new result |
| res_cnt | output | CW | Result magnitude in run-down clocks |
| res_neg | output | 1 | Result sign, 1 = negative input |
| res_ovr | output | 1 | Over-range, no crossing in the window |

## Verification
The bench uses short phase lengths and drives the comparator to place the crossing at run-down clock 0, at a clock in the middle of the window, and at the last clock. It also runs the window out with no crossing, under both signs. These cases separate an off-by-one count from a correct one and expose a missed final-clock crossing. They also show whether the switch pair follows the sign. During integration, the comparator shows the opposite sign until the last clock, which exposes a sign captured too early. Separate runs measure the cycle length with a mid-cycle low pulse on the run input, and with a long hold followed by a restart.

// File: rtl/dsadc_seq.sv
`timescale 1ns/1ps
module dsadc_seq #(
  parameter int AZ_LEN  = 32768,
  parameter int INT_LEN = 32768,
  parameter int CW      = $clog2(2*INT_LEN) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_hold,
  input  logic          cmp,
  output logic [8:0]    sw,
  output logic [1:0]    phase,
  output logic          res_valid,
  output logic [CW-1:0] res_cnt,
  output logic          res_neg,
  output logic          res_ovr
);
  localparam int DE_LEN = 2 * INT_LEN;
  localparam int TOTAL  = AZ_LEN + INT_LEN + DE_LEN;
  localparam int CYW    = $clog2(TOTAL);
  localparam logic [CYW-1:0] C_INT  = CYW'(AZ_LEN);
  localparam logic [CYW-1:0] C_DE   = CYW'(AZ_LEN + INT_LEN);
  localparam logic [CYW-1:0] C_LAST = CYW'(TOTAL - 1);

  localparam logic [8:0] SW_ZERO = 9'h10B;
  localparam logic [8:0] SW_INT  = 9'h10C;
  localparam logic [8:0] SW_POS  = 9'h0C0;
  localparam logic [8:0] SW_NEG  = 9'h120;

  logic [CYW-1:0] cyc;
  logic [CW-1:0]  dcnt;
  logic           pol, crossed;

  wire in_de     = cyc >= C_DE;
  wire in_int    = (cyc >= C_INT) && !in_de;
  wire last_int  = cyc == C_DE - CYW'(1);
  wire last_cyc  = cyc == C_LAST;
  wire parked    = (cyc == '0) && !run_hold;
  wire cross_now = in_de && !crossed && (cmp != pol);
  wire hit       = crossed || cross_now;

  assign phase = in_de ? 2'd2 : (in_int ? 2'd1 : 2'd0);

  always_comb begin
    if (in_de && !crossed) sw = pol ? SW_POS : SW_NEG;
    else if (in_int)       sw = SW_INT;
    else                   sw = SW_ZERO;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc       <= '0;
      dcnt      <= '0;
      pol       <= 1'b0;
      crossed   <= 1'b0;
      res_valid <= 1'b0;
      res_cnt   <= '0;
      res_neg   <= 1'b0;
      res_ovr   <= 1'b0;
    end else begin
      if (!parked) cyc <= last_cyc ? '0 : cyc + CYW'(1);

      if (last_int) begin
        pol     <= cmp;
        crossed <= 1'b0;
        dcnt    <= '0;
      end else if (in_de && !crossed) begin
        if (cmp != pol) crossed <= 1'b1;
        else            dcnt    <= dcnt + CW'(1);
      end

      res_valid <= last_cyc;
      if (last_cyc) begin
        res_cnt <= hit ? dcnt : dcnt + CW'(1);
        res_ovr <= !hit;
        res_neg <= !pol;
      end
    end
  end
endmodule

// File: rtl/dsadc_seq_chk.sv
`timescale 1ns/1ps
module dsadc_seq_chk #(
  parameter int CW   = 5,
  parameter int FULL = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [8:0]    sw,
  input logic [1:0]    phase,
  input logic          res_valid,
  input logic [CW-1:0] res_cnt,
  input logic          res_neg,
  input logic          res_ovr
);
  logic started;
  always_ff @(posedge clk) started <= rst_n;

  a_r1_int_after_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (started && phase == 2'd1 && $past(phase) != 2'd1) |-> $past(phase) == 2'd0);

  a_r1_de_after_int: assert property (@(posedge clk) disable iff (!rst_n)
    (started && phase == 2'd2 && $past(phase) != 2'd2) |-> $past(phase) == 2'd1);

  a_r3_loop_open: assert property (@(posedge clk) disable iff (!rst_n)
    sw[2] |-> !sw[0]);

  a_r5_ref_pair: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw[5] && sw[6]) && !(sw[7] && sw[8]));

  a_r7_ovr_full: assert property (@(posedge clk) disable iff (!rst_n)
    res_ovr |-> res_cnt == CW'(FULL));

  a_r8_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  a_r8_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    (started && !res_valid) |-> $stable({res_cnt, res_neg, res_ovr}));
endmodule

bind dsadc_seq dsadc_seq_chk #(.CW(CW), .FULL(2*INT_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw(sw), .phase(phase), .res_valid(res_valid),
  .res_cnt(res_cnt), .res_neg(res_neg), .res_ovr(res_ovr));

// File: tb/dsadc_seq_tb.sv
`timescale 1ns/1ps
module dsadc_seq_tb;
  localparam int AZ  = 8;
  localparam int INT = 8;
  localparam int DE  = 2 * INT;
  localparam int TOT = AZ + INT + DE;
  localparam int CW  = $clog2(DE) + 1;

  logic clk = 1'b0, rst_n = 1'b0, run_hold = 1'b1, cmp = 1'b0;
  logic [8:0] sw;
  logic [1:0] phase;
  logic res_valid, res_neg, res_ovr;
  logic [CW-1:0] res_cnt;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dsadc_seq #(.AZ_LEN(AZ), .INT_LEN(INT)) u_dut (
    .clk(clk), .rst_n(rst_n), .run_hold(run_hold), .cmp(cmp), .sw(sw),
    .phase(phase), .res_valid(res_valid), .res_cnt(res_cnt),
    .res_neg(res_neg), .res_ovr(res_ovr));

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    chk("R10", "phase", phase, 0);
    chk("R10", "sw", sw, 'h10B);
    chk("R10", "valid", res_valid, 0);
    chk("R10", "result", {res_cnt, res_neg, res_ovr}, 0);
  endtask

  task automatic t_conv(input bit p, input int k);
    while (phase != 2'd1) @(negedge clk);
    chk("R3", "integrate sw", sw, 'h10C);
    for (int i = 0; i < INT; i++) begin
      cmp = (i == INT - 1) ? p : !p;
      @(negedge clk);
    end
    chk("R1", "rundown phase", phase, 2);
    for (int j = 0; j < DE; j++) begin
      if (j == k) cmp = !p;
      if (j == 0) chk("R5", "ref pair", sw, p ? 'h0C0 : 'h120);
      if (j == k + 1) chk("R6", "zero set after crossing", sw, 'h10B);
      if (j == DE - 1 && k < DE - 1) chk("R6", "zero set at window end", sw, 'h10B);
      @(negedge clk);
    end
    chk("R8", "valid strobe", res_valid, 1);
    chk("R6", "count", res_cnt, (k < DE) ? k : DE);
    chk("R7", "over-range", res_ovr, (k >= DE) ? 1 : 0);
    chk("R4", "sign", res_neg, p ? 0 : 1);
    chk("R2", "zeroing sw", sw, 'h10B);
    @(negedge clk);
    chk("R8", "strobe width", res_valid, 0);
    cmp = p;
  endtask

  task automatic t_period();
    int n = 0;
    while (!res_valid) @(negedge clk);
    do begin
      if (n == 5) run_hold = 1'b0;
      if (n == 9) run_hold = 1'b1;
      @(negedge clk);
      n++;
    end while (!res_valid && n < 4 * TOT);
    chk("R1", "cycle length", n, TOT);
    chk("R9", "mid-cycle low ignored", n, TOT);
  endtask

  task automatic t_hold();
    logic [CW+1:0] kept;
    int bad = 0, n = 0;
    while (!res_valid) @(negedge clk);
    run_hold = 1'b0;
    kept = {res_cnt, res_neg, res_ovr};
    for (int i = 0; i < 3 * TOT; i++) begin
      @(negedge clk);
      if (phase != 2'd0 || res_valid || sw != 9'h10B) bad++;
    end
    chk("R9", "parked in zeroing", bad, 0);
    chk("R9", "result kept", {res_cnt, res_neg, res_ovr}, kept);
    run_hold = 1'b1;
    do begin @(negedge clk); n++; end while (!res_valid && n < 4 * TOT);
    chk("R9", "restart length", n, TOT);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_conv(1'b1, 5);
    t_conv(1'b0, 11);
    t_conv(1'b1, 0);
    t_conv(1'b0, DE - 1);
    t_conv(1'b1, DE);
    t_conv(1'b0, DE);
    t_period();
    t_hold();
    t_conv(1'b1, 3);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule